// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Window Check

This block is the digital half of a 10-bit successive-approximation converter. It drives the code of an external DAC and the sample/hold control. It powers the input amplifier and gives it a settle strobe. It reads back one comparator bit. A conversion first samples with the DAC parked at midscale. It then resolves the input one bit at a time, from the most significant bit down, and returns the code with a one-cycle done pulse.

A second operation skips the search and tests the input against two limits. The lower code goes out first and the comparator must report that the input is not below it. The upper code goes out next and the comparator must report that the input is below it. The block then pulses a valid strobe together with a pass flag. After reset, and whenever the enable is raised again, one throw-away conversion runs before any request is served. Its result is never reported.

The comparator bit `cmp_below` is 1 when the input lies below the DAC level and 0 otherwise.

Top module: `sar_window_ctrl`

## Requirements
- R1: A conversion makes exactly 10 decisions, from bit 9 down to bit 0. Each step sets the trial bit. The step clears that bit when `cmp_below` is 1. For a steady input V in 0..1023, the reported `result` equals V.
- R2: While `hold` is low, `dac_code` is 0x200. `hold` is low in idle and during the one-cycle sample phase.
- R3: Each comparator decision is taken one clock after the code it judges was applied. When the request is sampled at clock edge 0, `done` is seen after edge 11. A window check reports after edge 3.
- R4: `done` is a one-cycle pulse. `result` changes only together with `done` and holds its value afterwards.
- R5: `start` is ignored while an operation is running, while `en` is low, and while the dummy conversion is pending.
- R6: `amp_en` follows `en` with one clock of delay. `st` is high for exactly the first two cycles in which `amp_en` is high, and low at all other times.
- R7: In a window check the code `lo_code` is applied first, then `hi_code`, each for one cycle with `hold` high. `win_valid` pulses for one cycle. `win_pass` is 1 only if `cmp_below` was 0 at the lower code and 1 at the upper code. For a steady input V this means lo_code <= V < hi_code.
- R8: After reset, and after `en` has been low, the first operation with `en` high is a dummy conversion. The dummy produces no `done` pulse and leaves `result` unchanged. Dropping `en` aborts any operation.
- R9: Synchronous reset gives `hold` low, `dac_code` 0x200, `st` low, `amp_en` low, `done` and `win_valid` low, `result` 0, and the dummy armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Converter enable |
| start | input | 1 | Operation request, sampled in idle |
| mode_win | input | 1 | 0 selects conversion, 1 selects window check |
| lo_code | input | 10 | Lower window limit |
| hi_code | input | 10 | Upper window limit |
| cmp_below | input | 1 | Comparator: 1 when the input is below the DAC level |
| dac_code | output | 10 | Code driven to the DAC |
| hold | output | 1 | 0 while sampling, 1 while comparing |
| amp_en | output | 1 | Amplifier enable |
| st | output | 1 | Amplifier settle strobe |
| result | output | 10 | Last conversion result |
| done | output | 1 | One-cycle conversion complete pulse |
| win_valid | output | 1 | One-cycle window verdict pulse |
| win_pass | output | 1 | Window verdict |

## Verification
A wrong phase or bit index shows up at `dac_code` in the very next cycle. The reference model predicts every trial code, so a bad search step shows as a miscompare before `done`. A result that is off by one bit would otherwise appear only at the end. A lost dummy flag shows as a `done` pulse about twelve cycles after enable, where none is expected. A stuck settle counter shows on `st` in the third cycle after `amp_en` rises.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int DAC_W  = 10;
    localparam int IDX_W  = $clog2(DAC_W);

    typedef logic [DAC_W-1:0] code_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_CONV,
        PH_WLO,
        PH_WHI
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        code_t             trial;
        logic              win_op;
        logic              is_dummy;
        logic              dummy_pend;
        logic              lo_ok;
    } seq_t;

    function automatic code_t midscale();
        code_t m;
        m = '0;
        m[DAC_W-1] = 1'b1;
        return m;
    endfunction

    function automatic code_t bit_at(input logic [IDX_W-1:0] i);
        return code_t'(1) << i;
    endfunction

endpackage

// File: rtl/sar_amp_timer.sv
module sar_amp_timer #(
    parameter int ST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic amp_en,
    output logic st
);
    localparam int AGE_W = $clog2(ST_CYCLES + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ST_CYCLES);

    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_en <= 1'b0;
            age    <= '0;
        end else begin
            amp_en <= en;
            if (!amp_en)
                age <= '0;
            else if (age != AGE_MAX)
                age <= age + 1'b1;
        end
    end

    assign st = amp_en && (age < AGE_MAX);

endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  start,
    input  logic  mode_win,
    input  logic  cmp_below,
    output seq_t  seq,
    output code_t result,
    output logic  done,
    output logic  win_valid,
    output logic  win_pass
);
    code_t kept;

    always_comb begin
        kept = seq.trial;
        if (cmp_below)
            kept = seq.trial & ~bit_at(seq.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq.phase      <= PH_IDLE;
            seq.idx        <= '0;
            seq.trial      <= midscale();
            seq.win_op     <= 1'b0;
            seq.is_dummy   <= 1'b0;
            seq.dummy_pend <= 1'b1;
            seq.lo_ok      <= 1'b0;
            result         <= '0;
            done           <= 1'b0;
            win_valid      <= 1'b0;
            win_pass       <= 1'b0;
        end else begin
            done      <= 1'b0;
            win_valid <= 1'b0;
            if (!en) begin
                seq.phase      <= PH_IDLE;
                seq.dummy_pend <= 1'b1;
            end else begin
                unique case (seq.phase)
                    PH_IDLE: begin
                        if (seq.dummy_pend || start) begin
                            seq.phase    <= PH_SAMPLE;
                            seq.is_dummy <= seq.dummy_pend;
                            seq.win_op   <= !seq.dummy_pend && mode_win;
                        end
                    end
                    PH_SAMPLE: begin
                        if (seq.win_op) begin
                            seq.phase <= PH_WLO;
                        end else begin
                            seq.phase <= PH_CONV;
                            seq.idx   <= IDX_W'(DAC_W - 1);
                            seq.trial <= midscale();
                        end
                    end
                    PH_CONV: begin
                        if (seq.idx == '0) begin
                            seq.phase      <= PH_IDLE;
                            seq.dummy_pend <= 1'b0;
                            if (!seq.is_dummy) begin
                                result <= kept;
                                done   <= 1'b1;
                            end
                        end else begin
                            seq.trial <= kept | bit_at(seq.idx - 1'b1);
                            seq.idx   <= seq.idx - 1'b1;
                        end
                    end
                    PH_WLO: begin
                        seq.lo_ok <= !cmp_below;
                        seq.phase <= PH_WHI;
                    end
                    PH_WHI: begin
                        win_pass  <= seq.lo_ok && cmp_below;
                        win_valid <= 1'b1;
                        seq.phase <= PH_IDLE;
                    end
                    default: seq.phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sar_dac_mux.sv
module sar_dac_mux
    import sar_pkg::*;
(
    input  seq_t  seq,
    input  code_t lo_code,
    input  code_t hi_code,
    output code_t dac_code,
    output logic  hold
);
    always_comb begin
        hold     = 1'b1;
        dac_code = midscale();
        unique case (seq.phase)
            PH_CONV: dac_code = seq.trial;
            PH_WLO:  dac_code = lo_code;
            PH_WHI:  dac_code = hi_code;
            default: hold     = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_window_ctrl.sv
module sar_window_ctrl
    import sar_pkg::*;
#(
    parameter int ST_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic             mode_win,
    input  logic [DAC_W-1:0] lo_code,
    input  logic [DAC_W-1:0] hi_code,
    input  logic             cmp_below,
    output logic [DAC_W-1:0] dac_code,
    output logic             hold,
    output logic             amp_en,
    output logic             st,
    output logic [DAC_W-1:0] result,
    output logic             done,
    output logic             win_valid,
    output logic             win_pass
);
    seq_t seq;

    sar_amp_timer #(.ST_CYCLES(ST_CYCLES)) u_amp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .amp_en (amp_en),
        .st     (st)
    );

    sar_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start     (start),
        .mode_win  (mode_win),
        .cmp_below (cmp_below),
        .seq       (seq),
        .result    (result),
        .done      (done),
        .win_valid (win_valid),
        .win_pass  (win_pass)
    );

    sar_dac_mux u_mux (
        .seq      (seq),
        .lo_code  (lo_code),
        .hi_code  (hi_code),
        .dac_code (dac_code),
        .hold     (hold)
    );

endmodule

// File: rtl/sar_window_ctrl_chk.sv
module sar_window_ctrl_chk
    import sar_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [DAC_W-1:0] dac_code,
    input logic             hold,
    input logic             amp_en,
    input logic             st,
    input logic [DAC_W-1:0] result,
    input logic             done,
    input logic             win_valid
);
    AST_SAMPLE_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        !hold |-> dac_code == midscale());                            // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));                                   // R4
    AST_WINDOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        win_valid |=> !win_valid);                                    // R7
    AST_ST_NEEDS_AMP: assert property (@(posedge clk) disable iff (rst)
        st |-> amp_en);                                               // R6
    AST_ST_ON_AMP_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(amp_en) |-> st);                                        // R6
    AST_AMP_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
        en |=> amp_en);                                               // R6
    AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(en));                                          // R8
endmodule

bind sar_window_ctrl sar_window_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .dac_code  (dac_code),
    .hold      (hold),
    .amp_en    (amp_en),
    .st        (st),
    .result    (result),
    .done      (done),
    .win_valid (win_valid)
);

// File: tb/sar_window_ctrl_bench.sv
`timescale 1ns/1ps
module sar_window_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, start = 1'b0, mode_win = 1'b0;
    logic [9:0] lo_code = '0, hi_code = '0;
    logic       cmp_below;
    logic [9:0] dac_code, result;
    logic       hold, amp_en, st, done, win_valid, win_pass;
    int         vin = 0;
    int         vectors = 0, misses = 0, done_seen = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    assign cmp_below = vin < int'(dac_code);

    sar_window_ctrl u_sar_window_ctrl (
        .clk(clk), .rst(rst), .en(en), .start(start), .mode_win(mode_win),
        .lo_code(lo_code), .hi_code(hi_code), .cmp_below(cmp_below),
        .dac_code(dac_code), .hold(hold), .amp_en(amp_en), .st(st),
        .result(result), .done(done), .win_valid(win_valid), .win_pass(win_pass)
    );

    // reference model: step -1 idle, 0 sample, 1.. compare steps
    int m_step, m_acc, m_res, m_age, m_kind;
    bit m_dummy, m_isdum, m_amp, m_done, m_wv, m_pass, m_look;

    function automatic int exp_dac();
        if (m_step >= 1 && m_kind == 0) return m_acc | (1 << (10 - m_step));
        if (m_step == 1 && m_kind == 1) return int'(lo_code);
        if (m_step == 2 && m_kind == 1) return int'(hi_code);
        return 512;
    endfunction

    always @(posedge clk) begin
        int bitv, nacc;
        if (rst) begin
            m_step <= -1; m_acc <= 0; m_res <= 0; m_age <= 0; m_kind <= 0;
            m_dummy <= 1; m_isdum <= 0; m_amp <= 0; m_done <= 0;
            m_wv <= 0; m_pass <= 0; m_look <= 0;
        end else begin
            m_amp  <= en;
            m_age  <= m_amp ? ((m_age < 2) ? m_age + 1 : 2) : 0;
            m_done <= 0;
            m_wv   <= 0;
            if (!en) begin
                m_step <= -1; m_dummy <= 1;
            end else if (m_step == -1) begin
                if (m_dummy || start) begin
                    m_step <= 0; m_isdum <= m_dummy; m_acc <= 0;
                    m_kind <= (!m_dummy && mode_win) ? 1 : 0;
                end
            end else if (m_step == 0) begin
                m_step <= 1;
            end else if (m_kind == 0) begin
                bitv = 1 << (10 - m_step);
                nacc = (vin >= (m_acc | bitv)) ? (m_acc | bitv) : m_acc;
                if (m_step == 10) begin
                    if (!m_isdum) m_res <= nacc;
                    m_done <= !m_isdum; m_dummy <= 0; m_step <= -1;
                end else begin
                    m_acc <= nacc; m_step <= m_step + 1;
                end
            end else if (m_step == 1) begin
                m_look <= vin >= int'(lo_code); m_step <= 2;
            end else begin
                m_pass <= m_look && (vin < int'(hi_code));
                m_wv <= 1; m_step <= -1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) done_seen++;
            check("R1/R2/R7 dac_code", int'(dac_code), exp_dac());
            check("R2 hold", int'(hold), (m_step >= 1) ? 1 : 0);
            check("R6 amp_en", int'(amp_en), int'(m_amp));
            check("R6 st", int'(st), (m_amp && m_age < 2) ? 1 : 0);
            check("R4/R8 done", int'(done), int'(m_done));
            check("R4 result", int'(result), m_res);
            check("R7 win_valid", int'(win_valid), int'(m_wv));
            if (win_valid) check("R7 win_pass", int'(win_pass), int'(m_pass));
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    task automatic convert(input int v, input bit poke_busy);
        int n;
        vin = v;
        @(negedge clk); start = 1; mode_win = 0;
        @(negedge clk); start = 0; n = 1;
        while (!done && n < 30) begin
            if (poke_busy && n == 4) start = 1;
            @(negedge clk); start = 0; n++;
        end
        check("R3 conversion latency", n, 12);
        check("R1 result value", int'(result), v);
        repeat (3) @(negedge clk);
        if (poke_busy) check("R5 busy start ignored, hold", int'(hold), 0);
    endtask

    task automatic window(input int v, input int lo, input int hi);
        int n;
        vin = v; lo_code = 10'(lo); hi_code = 10'(hi);
        @(negedge clk); start = 1; mode_win = 1;
        @(negedge clk); start = 0; n = 1;
        while (!win_valid && n < 30) begin @(negedge clk); n++; end
        check("R3 window latency", n, 4);
        check("R7 window verdict", int'(win_pass), (v >= lo && v < hi) ? 1 : 0);
        mode_win = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset dac", int'(dac_code), 512);
        check("R9 reset hold", int'(hold), 0);
        check("R9 reset st", int'(st), 0);
        check("R9 reset amp_en", int'(amp_en), 0);
        check("R9 reset result", int'(result), 0);
        rst = 0;
        @(negedge clk); en = 1; vin = 700;
        @(negedge clk);
        check("R6 st first cycle", int'(st), 1);
        @(negedge clk); check("R6 st second cycle", int'(st), 1);
        @(negedge clk); check("R6 st third cycle", int'(st), 0);
        repeat (14) @(negedge clk);
        check("R8 dummy gives no done", done_seen, 0);
        check("R8 dummy leaves result", int'(result), 0);
        convert(0, 0);
        convert(1023, 0);
        convert(512, 1);
        convert(511, 0);
        convert(37, 0);
        convert(868, 0);
        convert(613, 0);
        window(300, 200, 400);
        window(150, 200, 400);
        window(450, 200, 400);
        window(200, 200, 400);
        window(400, 200, 400);
        // abort and re-arm the dummy; start during dummy is ignored
        vin = 123;
        @(negedge clk); start = 1;
        repeat (5) @(negedge clk);
        start = 0; en = 0;
        repeat (3) @(negedge clk);
        check("R8 abort returns hold low", int'(hold), 0);
        done_seen = 0;
        en = 1; start = 1;
        @(negedge clk); start = 0;
        repeat (16) @(negedge clk);
        check("R5/R8 no done after re-enable", done_seen, 0);
        convert(123, 0);
        finish_run();
    end

    initial begin
        #(5ns * 20000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule